// File: doc/BRIEF.md
# Block Address Translation Matcher

This block is a small fully associative array of block-translation entries that a memory pipeline consults before it starts a page-table walk. It keeps two independent sets of entries, one used by instruction fetches and one used by loads and stores. Each entry is a pair of 32-bit words: an upper word that says which effective-address block the entry covers, how large that block is and in which privilege states it is usable, and a lower word that gives the real block base and the access rights.

For every lookup the block takes an effective address, an access kind and the privilege state. One clock later it returns a hit flag, the translated real page number, the read/write/execute rights of the matching entry and a protection-fault flag. The fault flag is raised when the access hits but the entry does not grant the right the access needs. Entries are written one word at a time through a simple configuration port. Blocks can be any power-of-two size from 128 KiB to 256 MiB, selected by a length mask. When more than one entry matches, the lowest-indexed one is used.

Top module: `bat_xlate`

## Requirements
- R1: After a synchronous reset every entry word on both sides is zero, so every lookup misses, and all response outputs are zero.
- R2: A fetch (req_kind 2'b10) searches only the instruction-side entries. A load (2'b00), a store (2'b01) and the reserved code 2'b11, which behaves as a load, search only the data-side entries.
- R3: Upper-word bit 0 enables an entry in user state (req_user=1) and bit 1 enables it in supervisor state (req_user=0). An entry that is not enabled for the current state never hits.
- R4: The block mask is 32'hFFFE_0000 with every bit cleared that is set in (upper & 32'h0000_1FFC) << 15. An enabled entry hits when (ea & mask) equals upper & 32'hFFFE_0000, so an entry whose base has bits set inside its own block never hits.
- R5: On a hit, rsp_rpage is bits 31:12 of (lower & mask) | (ea & ~mask).
- R6: When several entries on the searched side hit, the one with the lowest index supplies every response field.
- R7: Lower-word bits 1:0 give the rights: 2'b00 grants nothing, 2'b01 and 2'b11 grant read and execute, and 2'b10 grants read, write and execute.
- R8: rsp_prot_fault is 1 exactly when the access hits and lacks its right: execute for a fetch, write for a store, read for a load or the reserved code. It is never 1 on a miss.
- R9: Each response is registered. rsp_valid equals req_valid of the previous cycle. If that request missed or was absent, rsp_hit, rsp_rpage, the rights and the fault are all zero.
- R10: cfg_we writes cfg_wdata into the upper word (cfg_hi=1) or the lower word (cfg_hi=0) of entry cfg_idx on the instruction side (cfg_side=1) or the data side (cfg_side=0). A lookup in the same cycle as the write still sees the old contents, and a lookup in any later cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_side | input | 1 | 1 = instruction side, 0 = data side |
| cfg_idx | input | 2 | Entry index to write |
| cfg_hi | input | 1 | 1 = upper word, 0 = lower word |
| cfg_wdata | input | 32 | Word to write |
| req_valid | input | 1 | Lookup request present |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 treated as load |
| req_user | input | 1 | 1 = user state, 0 = supervisor state |
| req_ea | input | 32 | Effective address |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | An entry matched |
| rsp_rpage | output | 20 | Real page number (address bits 31:12) |
| rsp_rd | output | 1 | Read right of the matching entry |
| rsp_wr | output | 1 | Write right of the matching entry |
| rsp_ex | output | 1 | Execute right of the matching entry |
| rsp_prot_fault | output | 1 | Hit without the required right |

## Verification
The hardest case to reach from the ports is an address that two or more entries of the same side cover at once, each enabled for the current privilege state. This has to happen while the entries differ in block size, so that the priority rule and the mask arithmetic are tested together. Uniformly random addresses almost never land in any block. The stimulus therefore builds most lookup addresses from the base of an entry it has already programmed and randomises only the bits inside that entry's block. Block lengths are drawn from a set biased toward 128 KiB and 256 MiB, so nested blocks come up often. Directed cases add deliberate overlaps, bases with bits set inside their own block, and a write that lands in the same cycle as a lookup.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int ADDR_W    = 32;
    localparam int PAGE_BITS = 12;
    localparam int RPN_W     = ADDR_W - PAGE_BITS;
    localparam int BASE_LSB  = 17;
    localparam int LEN_LSB   = 2;
    localparam int LEN_W     = 11;
    localparam int LEN_SHIFT = 15;
    localparam int BIT_UVAL  = 0;
    localparam int BIT_SVAL  = 1;

    localparam logic [ADDR_W-1:0] BASE_FIELD =
        {{(ADDR_W-BASE_LSB){1'b1}}, {BASE_LSB{1'b0}}};
    localparam logic [ADDR_W-1:0] LEN_FIELD =
        {{(ADDR_W-LEN_LSB-LEN_W){1'b0}}, {LEN_W{1'b1}}, {LEN_LSB{1'b0}}};

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic {
        SIDE_DATA  = 1'b0,
        SIDE_INSTR = 1'b1
    } side_e;

    typedef struct packed {
        logic [ADDR_W-1:0] upper;
        logic [ADDR_W-1:0] lower;
    } blk_pair_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    typedef struct packed {
        logic             hit;
        logic [RPN_W-1:0] rpage;
        perm_t            perm;
    } match_t;

    function automatic logic [ADDR_W-1:0] block_mask(input logic [ADDR_W-1:0] upper);
        return BASE_FIELD & ~((upper & LEN_FIELD) << LEN_SHIFT);
    endfunction

    function automatic perm_t decode_rights(input logic [1:0] code);
        perm_t p;
        p.rd = (code != 2'b00);
        p.ex = (code != 2'b00);
        p.wr = (code == 2'b10);
        return p;
    endfunction

    function automatic logic right_granted(input acc_kind_e kind, input perm_t p);
        case (kind)
            ACC_FETCH: return p.ex;
            ACC_STORE: return p.wr;
            default:   return p.rd;
        endcase
    endfunction

endpackage

// File: rtl/bat_regfile.sv
module bat_regfile
    import bat_pkg::*;
#(
    parameter int N_ENTRIES = 4,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_we,
    input  logic                         cfg_side,
    input  logic [IDX_W-1:0]             cfg_idx,
    input  logic                         cfg_hi,
    input  logic [ADDR_W-1:0]            cfg_wdata,
    output blk_pair_t [N_ENTRIES-1:0]    instr_q,
    output blk_pair_t [N_ENTRIES-1:0]    data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            instr_q <= '0;
            data_q  <= '0;
        end else if (cfg_we) begin
            if (cfg_side == SIDE_INSTR) begin
                if (cfg_hi) instr_q[cfg_idx].upper <= cfg_wdata;
                else        instr_q[cfg_idx].lower <= cfg_wdata;
            end else begin
                if (cfg_hi) data_q[cfg_idx].upper <= cfg_wdata;
                else        data_q[cfg_idx].lower <= cfg_wdata;
            end
        end
    end

    AST_CFG_INSTR_UPPER: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_side && cfg_hi) |=> instr_q[$past(cfg_idx)].upper == $past(cfg_wdata)); // R10
    AST_CFG_DATA_LOWER: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_side && !cfg_hi) |=> data_q[$past(cfg_idx)].lower == $past(cfg_wdata)); // R10

endmodule

// File: rtl/bat_entry_match.sv
module bat_entry_match
    import bat_pkg::*;
(
    input  blk_pair_t         pair,
    input  logic [ADDR_W-1:0] ea,
    input  logic              user,
    output match_t            res
);

    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] raddr;
    logic              enabled;
    logic              match;

    always_comb begin
        mask    = block_mask(pair.upper);
        enabled = user ? pair.upper[BIT_UVAL] : pair.upper[BIT_SVAL];
        match   = enabled && ((ea & mask) == (pair.upper & BASE_FIELD));
        raddr   = (pair.lower & mask) | (ea & ~mask);
        res     = '0;
        if (match) begin
            res.hit   = 1'b1;
            res.rpage = raddr[ADDR_W-1:PAGE_BITS];
            res.perm  = decode_rights(pair.lower[1:0]);
        end
    end

endmodule

// File: rtl/bat_first_hit.sv
module bat_first_hit
    import bat_pkg::*;
#(
    parameter int N_ENTRIES = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  match_t [N_ENTRIES-1:0]    cand,
    output match_t                    pick
);

    logic [N_ENTRIES-1:0] hits;
    logic [N_ENTRIES-1:0] grant;
    logic                 taken;

    always_comb begin
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            hits[i] = cand[i].hit;
            if (cand[i].hit && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    always_comb begin
        pick = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (grant[i]) pick = match_t'(pick | cand[i]);
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R6
    AST_ANY_HIT_PICKED: assert property (@(posedge clk) disable iff (rst)
        (|hits) |-> pick.hit); // R6

endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
    import bat_pkg::*;
#(
    parameter int N_ENTRIES = 4,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_side,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_hi,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_user,
    input  logic [31:0]       req_ea,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [19:0]       rsp_rpage,
    output logic              rsp_rd,
    output logic              rsp_wr,
    output logic              rsp_ex,
    output logic              rsp_prot_fault
);

    blk_pair_t [N_ENTRIES-1:0] instr_q;
    blk_pair_t [N_ENTRIES-1:0] data_q;
    blk_pair_t [N_ENTRIES-1:0] sel_pairs;
    match_t    [N_ENTRIES-1:0] cand;
    match_t                    pick;
    acc_kind_e                 kind;

    bat_regfile #(.N_ENTRIES(N_ENTRIES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_side  (cfg_side),
        .cfg_idx   (cfg_idx),
        .cfg_hi    (cfg_hi),
        .cfg_wdata (cfg_wdata),
        .instr_q   (instr_q),
        .data_q    (data_q)
    );

    assign kind      = acc_kind_e'(req_kind);
    assign sel_pairs = (kind == ACC_FETCH) ? instr_q : data_q;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
        bat_entry_match u_match (
            .pair (sel_pairs[g]),
            .ea   (req_ea),
            .user (req_user),
            .res  (cand[g])
        );
    end

    bat_first_hit #(.N_ENTRIES(N_ENTRIES)) u_pick (
        .clk  (clk),
        .rst  (rst),
        .cand (cand),
        .pick (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_hit        <= 1'b0;
            rsp_rpage      <= '0;
            rsp_rd         <= 1'b0;
            rsp_wr         <= 1'b0;
            rsp_ex         <= 1'b0;
            rsp_prot_fault <= 1'b0;
        end else begin
            rsp_valid      <= req_valid;
            rsp_hit        <= req_valid && pick.hit;
            rsp_rpage      <= req_valid ? pick.rpage : '0;
            rsp_rd         <= req_valid && pick.perm.rd;
            rsp_wr         <= req_valid && pick.perm.wr;
            rsp_ex         <= req_valid && pick.perm.ex;
            rsp_prot_fault <= req_valid && pick.hit && !right_granted(kind, pick.perm);
        end
    end

    AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        rsp_prot_fault |-> rsp_hit); // R8
    AST_MISS_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_rpage == '0 && !rsp_rd && !rsp_wr && !rsp_ex)); // R9
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R9
    AST_STORE_FAULT_NO_WR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && kind == ACC_STORE) |=> (rsp_prot_fault |-> !rsp_wr)); // R8
    AST_WRITE_IMPLIES_READ: assert property (@(posedge clk) disable iff (rst)
        rsp_wr |-> (rsp_rd && rsp_ex)); // R7

endmodule

// File: tb/sim_bat_xlate.sv
`timescale 1ns/1ps
module sim_bat_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_side = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic        cfg_hi = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic [31:0] req_ea = '0;
    logic        rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ex, rsp_prot_fault;
    logic [19:0] rsp_rpage;

    int n_checks = 0;
    int n_fails  = 0;

    logic [31:0] m_up [2][4];
    logic [31:0] m_lo [2][4];

    always #10 clk = ~clk;

    bat_xlate u0 (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_side(cfg_side), .cfg_idx(cfg_idx), .cfg_hi(cfg_hi), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_kind(req_kind), .req_user(req_user), .req_ea(req_ea),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rpage(rsp_rpage),
        .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_ex(rsp_ex), .rsp_prot_fault(rsp_prot_fault)
    );

    function automatic logic [31:0] ref_mask(input logic [31:0] up);
        return 32'hFFFE_0000 & ~((up & 32'h0000_1FFC) << 15);
    endfunction

    // expected {valid, hit, rpage, rd, wr, ex, fault}
    function automatic logic [25:0] ref_lookup(input logic [1:0] kind, input logic user,
                                               input logic [31:0] ea);
        int side;
        logic [31:0] m, ra, up, lo;
        logic rd, wr, ex, need;
        side = (kind == 2'b10) ? 1 : 0;
        for (int i = 0; i < 4; i++) begin
            up = m_up[side][i];
            lo = m_lo[side][i];
            m  = ref_mask(up);
            if ((user ? up[0] : up[1]) && ((ea & m) == (up & 32'hFFFE_0000))) begin
                ra = (lo & m) | (ea & ~m);
                rd = (lo[1:0] != 2'b00);
                ex = rd;
                wr = (lo[1:0] == 2'b10);
                need = (kind == 2'b10) ? ex : (kind == 2'b01) ? wr : rd;
                return {1'b1, 1'b1, ra[31:12], rd, wr, ex, !need};
            end
        end
        return {1'b1, 1'b0, 20'h0, 4'b0000};
    endfunction

    task automatic check(input string req, input logic [25:0] act, input logic [25:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [25:0] outs();
        return {rsp_valid, rsp_hit, rsp_rpage, rsp_rd, rsp_wr, rsp_ex, rsp_prot_fault};
    endfunction

    task automatic cfg_write(input logic side, input logic [1:0] idx, input logic hi,
                             input logic [31:0] d);
        cfg_we = 1'b1; cfg_side = side; cfg_idx = idx; cfg_hi = hi; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (hi) m_up[side][idx] = d; else m_lo[side][idx] = d;
    endtask

    task automatic lookup(input string req, input logic [1:0] kind, input logic user,
                          input logic [31:0] ea);
        logic [25:0] exp;
        exp = ref_lookup(kind, user, ea);
        req_valid = 1'b1; req_kind = kind; req_user = user; req_ea = ea;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, outs(), exp);
    endtask

    task automatic clear_all();
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 4; i++) begin
                cfg_write(s[0], i[1:0], 1'b1, 32'h0);
                cfg_write(s[0], i[1:0], 1'b0, 32'h0);
            end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [31:0] exp_old;
        logic [25:0] e;
        void'($urandom(32'd2024));
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 4; i++) begin m_up[s][i] = '0; m_lo[s][i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset outputs", outs(), 26'h0);
        lookup("R1 empty miss sup", 2'b00, 1'b0, 32'h0000_0000);
        lookup("R1 empty miss fetch", 2'b10, 1'b1, 32'h1234_5000);
        @(negedge clk);
        check("R9 idle outputs", outs(), 26'h0);

        // data entry 0: base 0x1000_0000, 128 KiB, supervisor only, RWX
        cfg_write(1'b0, 2'd0, 1'b1, 32'h1000_0002);
        cfg_write(1'b0, 2'd0, 1'b0, 32'h8000_0002);
        lookup("R5 sup load hit", 2'b00, 1'b0, 32'h1001_2345);
        lookup("R3 user miss", 2'b00, 1'b1, 32'h1001_2345);
        lookup("R2 fetch uses instr side", 2'b10, 1'b0, 32'h1001_2345);
        lookup("R2 reserved kind as load", 2'b11, 1'b0, 32'h1001_F000);
        lookup("R4 outside block", 2'b00, 1'b0, 32'h1002_0000);

        // instr entry 2: user only, read/exec, 256 MiB block
        cfg_write(1'b1, 2'd2, 1'b1, 32'h3000_1FFD);
        cfg_write(1'b1, 2'd2, 1'b0, 32'hA000_0001);
        lookup("R4 large block fetch", 2'b10, 1'b1, 32'h3ABC_DEF0);
        lookup("R3 sup miss", 2'b10, 1'b0, 32'h3ABC_DEF0);

        // data entry 1: read-only, user+sup -> store fault
        cfg_write(1'b0, 2'd1, 1'b1, 32'h2000_0003);
        cfg_write(1'b0, 2'd1, 1'b0, 32'h4000_0003);
        lookup("R8 store fault", 2'b01, 1'b1, 32'h2000_1000);
        lookup("R7 load code 11", 2'b00, 1'b1, 32'h2000_1000);
        cfg_write(1'b0, 2'd1, 1'b0, 32'h4000_0000);
        lookup("R8 load no rights", 2'b00, 1'b0, 32'h2000_1000);

        // priority: entries 2 and 3 overlap (3 is larger, 2 is smaller)
        cfg_write(1'b0, 2'd3, 1'b1, 32'h5000_01FF);
        cfg_write(1'b0, 2'd3, 1'b0, 32'h6000_0002);
        cfg_write(1'b0, 2'd2, 1'b1, 32'h5002_0003);
        cfg_write(1'b0, 2'd2, 1'b0, 32'h7000_0001);
        lookup("R6 lowest index wins", 2'b01, 1'b0, 32'h5003_0000);
        lookup("R6 only larger hits", 2'b00, 1'b0, 32'h5080_0000);

        // base with bits inside its own block never hits
        cfg_write(1'b1, 2'd0, 1'b1, 32'h9002_0007);
        cfg_write(1'b1, 2'd0, 1'b0, 32'hB000_0002);
        lookup("R4 unaligned base miss", 2'b10, 1'b0, 32'h9002_0000);
        lookup("R4 unaligned base miss2", 2'b10, 1'b0, 32'h9000_0000);

        // same-cycle write and lookup sees old contents
        exp_old = m_lo[0][0];
        e = ref_lookup(2'b00, 1'b0, 32'h1000_0000);
        cfg_we = 1'b1; cfg_side = 1'b0; cfg_idx = 2'd0; cfg_hi = 1'b0; cfg_wdata = 32'hC000_0001;
        req_valid = 1'b1; req_kind = 2'b00; req_user = 1'b0; req_ea = 32'h1000_0000;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        m_lo[0][0] = 32'hC000_0001;
        check("R10 same-cycle old value", outs(), e);
        if (exp_old[31:12] == 20'hC0000) check("R10 sanity", 26'h1, 26'h0);
        lookup("R10 next cycle new value", 2'b00, 1'b0, 32'h1000_0000);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 4; i++) begin m_up[s][i] = '0; m_lo[s][i] = '0; end
        lookup("R1 reset clears entries", 2'b00, 1'b0, 32'h1000_0000);

        // random phase
        for (int it = 0; it < 3000; it++) begin
            if ($urandom_range(0, 3) == 0) begin
                logic [31:0] up, lo, len;
                int pick;
                pick = $urandom_range(0, 5);
                len = (pick == 0) ? 32'h0 : (pick == 1) ? 32'h7FF : (pick == 2) ? 32'h1 :
                      (pick == 3) ? 32'h7F : {21'h0, $urandom_range(0, 2047)};
                up = ($urandom() & 32'hFFFE_0000) | (len << 2) | {30'h0, 2'($urandom_range(0, 3))};
                if ($urandom_range(0, 3) != 0) up = (up & ref_mask(up)) | (up & 32'h1FFF);
                lo = $urandom();
                cfg_write(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 1'b1, up);
                cfg_write(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 1'b0, lo);
            end else begin
                logic [1:0] kind;
                logic [31:0] ea, up;
                int side;
                kind = 2'($urandom_range(0, 3));
                side = (kind == 2'b10) ? 1 : 0;
                up = m_up[side][$urandom_range(0, 3)];
                if ($urandom_range(0, 9) < 7)
                    ea = (up & 32'hFFFE_0000) | ($urandom() & ~ref_mask(up));
                else
                    ea = $urandom();
                lookup("R4 R5 R6 R8 random", kind, 1'($urandom_range(0, 1)), ea);
            end
            if (it % 500 == 499) begin
                clear_all();
                lookup("R2 random cleared", 2'b10, 1'b0, $urandom());
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule